// File: doc/BRIEF.md
# UART Register and Interrupt Controller

This block is the software-facing side of a simple serial port. A word-addressed register bus reaches five registers through it: a byte data register, a baud divisor, a status register, a control register and a debug register. The divisor and a few control bits are exported to the baud generator and the shifter, which are not part of this block. Transmit bytes leave as a one-cycle strobe with the byte beside it. Receive bytes arrive through a valid/ready handshake.

Two sticky event flags record that a byte was received and that a byte was sent. Software clears each flag by writing a one to its status bit. One level interrupt is formed from the flags, each masked by its own enable. While an unread received byte is pending, the block holds receive ready low. The serial side therefore waits instead of overwriting the byte.

Register offsets in bytes: data 0x00, divisor 0x04, status 0x08, control 0x0C, debug 0x10. The register index is taken from address bits [ADDR_W-1:2], and bits [1:0] are ignored. Read data is combinational and is valid in the same cycle as a read request.

Top module: `uart_regif`

## Requirements
- R1: After reset, status reads 0x1, and data, divisor, control and debug read 0. `irq`, `tx_strobe` and `divisor` are 0, and `rx_ready` is 1. Status bit 0 (transmit holding empty) reads 1 at all times.
- R2: Divisor keeps `wdata[DIV_W-1:0]` and drives the `divisor` port. Control keeps bits [2:0]: bit 0 is the receive interrupt enable, bit 1 the transmit interrupt enable, and bit 2 drives `passthru_en`. Debug keeps bit 0, which drives `break_en`. All other bits of these registers read 0.
- R3: A write to data sets status bit 2 (transmit event). In the next cycle it also pulses `tx_strobe` high for one cycle, with `tx_data` equal to `wdata[7:0]`.
- R4: When `rx_valid` and `rx_ready` are both high at a clock edge, the block latches `rx_data`. Data then reads that byte, and status bit 1 (receive event) is set.
- R5: While the receive event is set, `rx_ready` is low and offered bytes are ignored, so data keeps the earlier byte.
- R6: A write to status clears bit 1 and/or bit 2 only where the written value has a one. Every other status bit is unaffected.
- R7: `irq` is a register. One cycle after any flag or enable change it equals (receive event AND control bit 0) OR (transmit event AND control bit 1).
- R8: If a byte is accepted in the same cycle as a status write that clears bit 1, the receive event ends up set and the new byte is latched.
- R9: Writes to offsets 0x14 to 0x1C change no register, and reads from those offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, same cycle as the read request |
| rx_valid | input | 1 | Receive engine offers a byte |
| rx_data | input | BYTE_W | Offered byte |
| rx_ready | output | 1 | Block can accept a byte |
| tx_strobe | output | 1 | One-cycle pulse: send `tx_data` |
| tx_data | output | BYTE_W | Byte to transmit |
| divisor | output | DIV_W | Baud divisor for the generator |
| passthru_en | output | 1 | Pass-through enable (control bit 2) |
| break_en | output | 1 | Break enable (debug bit 0) |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that a bus request lasts exactly one cycle. They also assume that the receive engine drops `rx_valid` once a byte is taken, and that no write to data coincides with a status write, since a single bus cannot issue both. The stimulus drives every bus request for one cycle between falling edges and offers each byte for one cycle only. It raises an offered byte together with a status write only in the set-priority case.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int unsigned REG_COUNT = 5;
  localparam int unsigned IDX_DATA  = 0;
  localparam int unsigned IDX_DIV   = 1;
  localparam int unsigned IDX_STAT  = 2;
  localparam int unsigned IDX_CTRL  = 3;
  localparam int unsigned IDX_DBG   = 4;

  localparam int unsigned ST_THRE = 0;
  localparam int unsigned ST_RX   = 1;
  localparam int unsigned ST_TX   = 2;

  localparam int unsigned CT_RXIE = 0;
  localparam int unsigned CT_TXIE = 1;
  localparam int unsigned CT_PASS = 2;
  localparam int unsigned CTRL_W  = 3;

  localparam int unsigned DB_BRK  = 0;
endpackage

// File: rtl/uart_regif_decode.sv
module uart_regif_decode
  import uart_regif_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  output logic [REG_COUNT-1:0] wr_sel,
  output logic [REG_COUNT-1:0] rd_sel
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             unused_addr_lsb;

  assign idx             = bus_addr[ADDR_W-1:2];
  assign unused_addr_lsb = ^bus_addr[1:0];

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_sel
    logic hit;
    assign hit       = bus_valid && (idx == IDX_W'(g));
    assign wr_sel[g] = hit && bus_write;
    assign rd_sel[g] = hit && !bus_write;
  end
endmodule

// File: rtl/uart_regif_events.sv
module uart_regif_events #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] tx_byte_in,
  input  logic              clr_rx,
  input  logic              clr_tx,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_evt,
  output logic              tx_evt,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_data
);
  logic              rx_evt_q, rx_evt_d;
  logic              tx_evt_q, tx_evt_d;
  logic [BYTE_W-1:0] rx_byte_q;
  logic [BYTE_W-1:0] tx_data_q;
  logic              tx_strobe_q;
  logic              rx_take;

  assign rx_take = rx_valid && !rx_evt_q;

  // Set has priority over write-one-to-clear.
  always_comb begin
    rx_evt_d = rx_evt_q;
    if (clr_rx)  rx_evt_d = 1'b0;
    if (rx_take) rx_evt_d = 1'b1;

    tx_evt_d = tx_evt_q;
    if (clr_tx)  tx_evt_d = 1'b0;
    if (data_wr) tx_evt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_evt_q    <= 1'b0;
      tx_evt_q    <= 1'b0;
      tx_strobe_q <= 1'b0;
    end else begin
      rx_evt_q    <= rx_evt_d;
      tx_evt_q    <= tx_evt_d;
      tx_strobe_q <= data_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte_q <= '0;
    end else if (rx_take) begin
      rx_byte_q <= rx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data_q <= '0;
    end else if (data_wr) begin
      tx_data_q <= tx_byte_in;
    end
  end

  assign rx_ready  = !rx_evt_q;
  assign rx_evt    = rx_evt_q;
  assign tx_evt    = tx_evt_q;
  assign rx_byte   = rx_byte_q;
  assign tx_strobe = tx_strobe_q;
  assign tx_data   = tx_data_q;
endmodule

// File: rtl/uart_regif_irq.sv
module uart_regif_irq #(
  parameter int unsigned SRC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] evt,
  input  logic [SRC_N-1:0] en,
  output logic             irq
);
  logic [SRC_N-1:0] gated;
  logic             irq_d, irq_q;

  for (genvar s = 0; s < SRC_N; s++) begin : g_src
    assign gated[s] = evt[s] && en[s];
  end

  assign irq_d = |gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_data,
  output logic [DIV_W-1:0]  divisor,
  output logic              passthru_en,
  output logic              break_en,
  output logic              irq
);
  localparam int unsigned SRC_N = 2;

  logic                 rst_meta_q, rst_sync_q;
  logic [REG_COUNT-1:0] wr_sel, rd_sel;
  logic [DIV_W-1:0]     div_q, div_d;
  logic [CTRL_W-1:0]    ctrl_q, ctrl_d;
  logic                 dbg_q, dbg_d;
  logic                 rx_evt, tx_evt;
  logic [BYTE_W-1:0]    rx_byte;
  logic                 rx_en_w, tx_en_w;
  logic                 unused_wdata;

  // Reset: asserted asynchronously, released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  uart_regif_decode #(.ADDR_W(ADDR_W)) decode_i (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .wr_sel    (wr_sel),
    .rd_sel    (rd_sel)
  );

  uart_regif_events #(.BYTE_W(BYTE_W)) events_i (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .data_wr    (wr_sel[IDX_DATA]),
    .tx_byte_in (bus_wdata[BYTE_W-1:0]),
    .clr_rx     (wr_sel[IDX_STAT] && bus_wdata[ST_RX]),
    .clr_tx     (wr_sel[IDX_STAT] && bus_wdata[ST_TX]),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .rx_evt     (rx_evt),
    .tx_evt     (tx_evt),
    .rx_byte    (rx_byte),
    .tx_strobe  (tx_strobe),
    .tx_data    (tx_data)
  );

  assign rx_en_w = ctrl_q[CT_RXIE];
  assign tx_en_w = ctrl_q[CT_TXIE];

  uart_regif_irq #(.SRC_N(SRC_N)) irq_i (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .evt   ({tx_evt, rx_evt}),
    .en    ({tx_en_w, rx_en_w}),
    .irq   (irq)
  );

  // Plain read/write configuration registers.
  always_comb begin
    div_d  = div_q;
    ctrl_d = ctrl_q;
    dbg_d  = dbg_q;
    if (wr_sel[IDX_DIV])  div_d  = bus_wdata[DIV_W-1:0];
    if (wr_sel[IDX_CTRL]) ctrl_d = bus_wdata[CTRL_W-1:0];
    if (wr_sel[IDX_DBG])  dbg_d  = bus_wdata[DB_BRK];
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      div_q  <= '0;
      ctrl_q <= '0;
      dbg_q  <= 1'b0;
    end else begin
      div_q  <= div_d;
      ctrl_q <= ctrl_d;
      dbg_q  <= dbg_d;
    end
  end

  // Read multiplexer; unmapped indices return zero.
  always_comb begin
    bus_rdata = '0;
    if (rd_sel[IDX_DATA]) bus_rdata[BYTE_W-1:0] = rx_byte;
    if (rd_sel[IDX_DIV])  bus_rdata[DIV_W-1:0]  = div_q;
    if (rd_sel[IDX_STAT]) begin
      bus_rdata[ST_THRE] = 1'b1;
      bus_rdata[ST_RX]   = rx_evt;
      bus_rdata[ST_TX]   = tx_evt;
    end
    if (rd_sel[IDX_CTRL]) bus_rdata[CTRL_W-1:0] = ctrl_q;
    if (rd_sel[IDX_DBG])  bus_rdata[DB_BRK]     = dbg_q;
  end

  assign divisor      = div_q;
  assign passthru_en  = ctrl_q[CT_PASS];
  assign break_en     = dbg_q;
  assign unused_wdata = ^bus_wdata;
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_strobe,
  input logic              irq,
  input logic              rx_evt,
  input logic              tx_evt,
  input logic              rx_en,
  input logic              tx_en
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             rd, wr;
  assign idx = bus_addr[ADDR_W-1:2];
  assign rd  = bus_valid && !bus_write;
  assign wr  = bus_valid && bus_write;

  a_r1_thre_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && idx == IDX_W'(2)) |-> bus_rdata[0]);

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && idx >= IDX_W'(5)) |-> (bus_rdata == '0));

  a_r3_strobe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IDX_W'(0)) |=> (tx_strobe && tx_evt));

  a_r3_strobe_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> $past(wr && idx == IDX_W'(0)));

  a_r5_take_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !rx_ready);

  a_r6_clear_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IDX_W'(2) && bus_wdata[2]) |=> !tx_evt);

  a_r7_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past((rx_evt && rx_en) || (tx_evt && tx_en)));

  a_r8_set_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && wr && idx == IDX_W'(2) && bus_wdata[1]) |=> rx_evt);
endmodule

bind uart_regif uart_regif_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_q),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .tx_strobe (tx_strobe),
  .irq       (irq),
  .rx_evt    (rx_evt),
  .tx_evt    (tx_evt),
  .rx_en     (rx_en_w),
  .tx_en     (tx_en_w)
);

// File: tb/uart_regif_tb_top.sv
`timescale 1ns/1ps
module uart_regif_tb_top;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned DIV_W  = 16;

  localparam logic [4:0] A_DATA = 5'h00;
  localparam logic [4:0] A_DIV  = 5'h04;
  localparam logic [4:0] A_STAT = 5'h08;
  localparam logic [4:0] A_CTRL = 5'h0C;
  localparam logic [4:0] A_DBG  = 5'h10;

  // {write, addr, data, expected read}
  localparam int NVEC = 13;
  localparam logic [69:0] VECS [0:NVEC-1] = '{
    {1'b1, 5'h04, 32'h0000_ABCD, 32'h0},
    {1'b0, 5'h04, 32'h0,         32'h0000_ABCD},
    {1'b1, 5'h04, 32'hFFFF_1234, 32'h0},
    {1'b0, 5'h04, 32'h0,         32'h0000_1234},
    {1'b1, 5'h0C, 32'hFFFF_FFF8, 32'h0},
    {1'b0, 5'h0C, 32'h0,         32'h0},
    {1'b1, 5'h0C, 32'h0000_0005, 32'h0},
    {1'b0, 5'h0C, 32'h0,         32'h5},
    {1'b1, 5'h10, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 5'h10, 32'h0,         32'h1},
    {1'b1, 5'h14, 32'h0000_DEAD, 32'h0},
    {1'b0, 5'h14, 32'h0,         32'h0},
    {1'b0, 5'h1C, 32'h0,         32'h0}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_valid, bus_write;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  logic              rx_valid, rx_ready;
  logic [BYTE_W-1:0] rx_data, tx_data;
  logic              tx_strobe, passthru_en, break_en, irq;
  logic [DIV_W-1:0]  divisor;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  uart_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_strobe(tx_strobe), .tx_data(tx_data), .divisor(divisor),
    .passthru_en(passthru_en), .break_en(break_en), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic offer(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
    bus_wdata = '0; rx_valid = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_rd(A_STAT, r); check("R1 status", r, 32'h1);
    bus_rd(A_DATA, r); check("R1 data", r, 32'h0);
    bus_rd(A_DIV,  r); check("R1 div", r, 32'h0);
    bus_rd(A_CTRL, r); check("R1 ctrl", r, 32'h0);
    bus_rd(A_DBG,  r); check("R1 dbg", r, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
    check("R1 tx_strobe", {31'b0, tx_strobe}, 32'h0);
    check("R1 divisor", {16'b0, divisor}, 32'h0);

    // R2 R9 table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i][69]) bus_wr(VECS[i][68:64], VECS[i][63:32]);
      else begin
        bus_rd(VECS[i][68:64], r);
        check($sformatf("R2 R9 vector %0d", i), r, VECS[i][31:0]);
      end
    end
    bus_rd(A_DIV, r); check("R9 div kept", r, 32'h1234);
    check("R2 divisor port", {16'b0, divisor}, 32'h1234);
    check("R2 passthru_en", {31'b0, passthru_en}, 32'h1);
    check("R2 break_en", {31'b0, break_en}, 32'h1);
    bus_wr(A_CTRL, 32'h0);

    // R3 transmit
    bus_wr(A_DATA, 32'h1A5);
    check("R3 strobe", {31'b0, tx_strobe}, 32'h1);
    check("R3 tx_data", {24'b0, tx_data}, 32'hA5);
    @(negedge clk);
    check("R3 strobe one cycle", {31'b0, tx_strobe}, 32'h0);
    bus_rd(A_STAT, r); check("R3 tx event", r, 32'h5);
    check("R7 masked", {31'b0, irq}, 32'h0);

    // R7 enable then clear with latency
    bus_wr(A_CTRL, 32'h2);
    check("R7 latency", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R7 tx irq", {31'b0, irq}, 32'h1);
    bus_wr(A_STAT, 32'h4);
    check("R7 still high", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R7 dropped", {31'b0, irq}, 32'h0);
    bus_rd(A_STAT, r); check("R6 tx cleared", r, 32'h1);

    // R4 receive
    bus_wr(A_CTRL, 32'h1);
    offer(8'h3C);
    check("R5 ready low", {31'b0, rx_ready}, 32'h0);
    bus_rd(A_DATA, r); check("R4 data", r, 32'h3C);
    bus_rd(A_STAT, r); check("R4 rx event", r, 32'h3);
    check("R7 rx irq", {31'b0, irq}, 32'h1);

    // R5 byte ignored while pending
    offer(8'h77);
    bus_rd(A_DATA, r); check("R5 data kept", r, 32'h3C);
    check("R5 still not ready", {31'b0, rx_ready}, 32'h0);

    // R6 selective clear
    bus_wr(A_DATA, 32'h00);
    bus_rd(A_STAT, r); check("R6 both set", r, 32'h7);
    bus_wr(A_STAT, 32'h2);
    bus_rd(A_STAT, r); check("R6 rx only", r, 32'h5);
    check("R6 ready back", {31'b0, rx_ready}, 32'h1);
    bus_wr(A_STAT, 32'hFFFF_FFFB);
    bus_rd(A_STAT, r); check("R6 bit2 zero keeps tx", r, 32'h5);
    bus_wr(A_STAT, 32'h4);
    bus_rd(A_STAT, r); check("R6 tx cleared", r, 32'h1);

    // R8 set wins over clear
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h99;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h2;
    @(negedge clk);
    rx_valid = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    check("R8 ready low", {31'b0, rx_ready}, 32'h0);
    bus_rd(A_DATA, r); check("R8 data", r, 32'h99);
    bus_rd(A_STAT, r); check("R8 rx event", r, 32'h3);
    bus_wr(A_STAT, 32'h2);
    bus_rd(A_STAT, r); check("R6 final", r, 32'h1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule